// File: doc/BRIEF.md
# Peripheral-Paced DMA Channel

This block is one DMA channel that copies bytes between a register file and a single peripheral register. Each copy starts on a hardware request. Software sets up the channel through a small write-only configuration port: a control byte, a peripheral low-address byte, and the first and last register-file addresses of the block to copy. The control byte picks one of seven trigger inputs. Each rising edge on the chosen trigger moves one unit, either one byte or a two-byte word. The copy can run in either direction.

The peripheral always sits in the top page of the 12-bit address space, so only its low byte is programmed. The register-file pointer steps through the block. After it serves the last address, it returns to the first one. The channel then either disables itself or keeps running, depending on the loop setting. An optional single-cycle interrupt marks the end of each block.

Each byte moves as one bus read followed by one bus write. The bus master port is valid/ready. Once `bus_valid` is high, the channel holds `bus_addr`, `bus_we` and `bus_wdata` steady until the slave raises `bus_ready`. A beat completes on a rising clock edge where both `bus_valid` and `bus_ready` are high. On a read beat (`bus_we` = 0), `bus_rdata` is captured in that same cycle. The slave may hold `bus_ready` low for any number of cycles.

Top module: `dmach_chan`

## Requirements
- R1: The control byte is written with `cfg_sel` = 0, using `cfg_data[7:0]`. Its fields are: bit 0 enable, bit 1 loop, bit 2 direction, bit 3 interrupt enable, bit 4 word mode, and bits 7:5 trigger select. Trigger select code k (0..6) chooses `trig[k]`. While enable is 1, a rising edge on the selected input starts one transfer. Edges on the other inputs start nothing.
- R2: With direction 0, data is read from the register file and written to the peripheral address. With direction 1, data is read from the peripheral address and written to the register file.
- R3: The peripheral address is hex F in bits 11:8, followed by the 8-bit I/O byte written with `cfg_sel` = 1. In word mode, bit 0 is forced to 0 for the first byte and set to 1 for the second.
- R4: Byte mode moves one byte per request and advances the register-file pointer by 1. Word mode moves two bytes per request, to or from consecutive register-file addresses, and advances the pointer by 2.
- R5: The start address is written with `cfg_sel` = 2 and the end address with `cfg_sel` = 3. Setting enable when it was 0 loads the pointer from the start address. With loop at 0, the transfer that uses the end address reloads the start address and clears enable. Later triggers then do nothing.
- R6: With loop at 1, the pointer wraps to the start address after the end-address transfer, and the channel stays enabled.
- R7: `irq` is a one-cycle pulse after the end-address transfer completes, but only when interrupt enable is 1. Otherwise `irq` stays low.
- R8: Trigger select code 7 never starts a transfer.
- R9: Requests are detected on rising edges, so a held-high trigger counts once. An edge that arrives while a transfer is running is kept, and that transfer is served once the current one finishes.
- R10: While the channel is disabled, or has no pending request, `bus_valid` stays low. Under back-pressure, `bus_valid`, `bus_addr` and `bus_we` hold their values until `bus_ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 I/O byte, 2 start, 3 end |
| cfg_data | input | 12 | Configuration write data |
| trig | input | 7 | Trigger request inputs |
| bus_valid | output | 1 | Bus request valid |
| bus_ready | input | 1 | Bus slave ready |
| bus_we | output | 1 | 1 = write beat, 0 = read beat |
| bus_addr | output | 12 | Bus address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, sampled on a read handshake |
| irq | output | 1 | End-of-block pulse |

## Verification
The bench builds the channel with its default parameters: a 12-bit address space, an 8-bit I/O byte and seven trigger inputs. With seven inputs, code 7 is the only select value that maps to no input, so the reserved-code case can be exercised directly. The 4-bit page value defaults to all ones, which puts every peripheral access into addresses F00 to FFF in the bench's byte-array model. A programmable slave delay of zero or three cycles gives both immediate handshakes and held requests. The longer delay also leaves room for a second trigger edge to arrive in the middle of a transfer.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  localparam int TSEL_W = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} st_e;

  typedef struct packed {
    logic [TSEL_W-1:0] src;
    logic              word;
    logic              irq_en;
    logic              dir;
    logic              loop;
    logic              en;
  } ctrl_t;

  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_IO    = 2'd1;
  localparam logic [1:0] SEL_START = 2'd2;
  localparam logic [1:0] SEL_END   = 2'd3;
endpackage

// File: rtl/dmach_trig.sv
module dmach_trig
  import dmach_pkg::*;
#(
  parameter int NTRIG = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NTRIG-1:0]  trig,
  input  logic [TSEL_W-1:0] sel,
  input  logic              arm,
  input  logic              take,
  output logic              pend
);
  logic [NTRIG-1:0] trig_q;
  logic [NTRIG-1:0] rise;
  logic             hit;

  assign rise = trig & ~trig_q;

  // codes at or above NTRIG match no input and never request
  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NTRIG; i++)
      if (sel == TSEL_W'(i)) hit = rise[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_q <= '0;
      pend   <= 1'b0;
    end else begin
      trig_q <= trig;
      if (!arm) pend <= 1'b0;
      else      pend <= (pend & ~take) | hit;
    end
  end
endmodule

// File: rtl/dmach_addr.sv
module dmach_addr #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  input  logic          word,
  input  logic [AW-1:0] first,
  input  logic [AW-1:0] last_addr,
  output logic [AW-1:0] cur,
  output logic          at_end
);
  localparam logic [AW-1:0] STEP_B = AW'(1);
  localparam logic [AW-1:0] STEP_W = AW'(2);

  assign at_end = (cur == last_addr);

  always_ff @(posedge clk) begin
    if (!rst_n)    cur <= '0;
    else if (load) cur <= first;
    else if (adv)  cur <= at_end ? first : cur + (word ? STEP_W : STEP_B);
  end
endmodule

// File: rtl/dmach_chan.sv
module dmach_chan
  import dmach_pkg::*;
#(
  parameter int AW    = 12,
  parameter int DW    = 8,
  parameter int IOW   = 8,
  parameter int NTRIG = 7,
  parameter logic [AW-IOW-1:0] PAGE = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [AW-1:0]    cfg_data,
  input  logic [NTRIG-1:0] trig,
  output logic             bus_valid,
  input  logic             bus_ready,
  output logic             bus_we,
  output logic [AW-1:0]    bus_addr,
  output logic [DW-1:0]    bus_wdata,
  input  logic [DW-1:0]    bus_rdata,
  output logic             irq
);
  localparam int CW = $bits(ctrl_t);

  ctrl_t          ctrl;
  logic [IOW-1:0] io_q;
  logic [AW-1:0]  start_q, stop_q;
  st_e            state;
  logic           idx;
  logic [DW-1:0]  dat_q;
  logic           pend, take, done, load;
  logic [AW-1:0]  cur, rf_addr, per_addr, src_addr, dst_addr;
  logic           at_end;
  ctrl_t          ctrl_in;

  assign ctrl_in = ctrl_t'(cfg_data[CW-1:0]);
  assign load    = cfg_we && cfg_sel == SEL_CTRL && ctrl_in.en && !ctrl.en;
  assign take    = state == ST_IDLE && pend && ctrl.en;
  assign done    = state == ST_WR && bus_ready && (!ctrl.word || idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl    <= '0;
      io_q    <= '0;
      start_q <= '0;
      stop_q  <= '0;
    end else begin
      if (cfg_we && cfg_sel == SEL_CTRL)       ctrl    <= ctrl_in;
      else if (done && at_end && !ctrl.loop)   ctrl.en <= 1'b0;
      if (cfg_we && cfg_sel == SEL_IO)         io_q    <= cfg_data[IOW-1:0];
      if (cfg_we && cfg_sel == SEL_START)      start_q <= cfg_data;
      if (cfg_we && cfg_sel == SEL_END)        stop_q  <= cfg_data;
    end
  end

  dmach_trig #(.NTRIG(NTRIG)) u_trig (
    .clk(clk), .rst_n(rst_n), .trig(trig), .sel(ctrl.src),
    .arm(ctrl.en), .take(take), .pend(pend)
  );

  dmach_addr #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(load), .adv(done), .word(ctrl.word),
    .first(start_q), .last_addr(stop_q), .cur(cur), .at_end(at_end)
  );

  assign rf_addr  = cur + AW'(idx);
  assign per_addr = {PAGE, io_q[IOW-1:1], ctrl.word ? idx : io_q[0]};
  assign src_addr = ctrl.dir ? per_addr : rf_addr;
  assign dst_addr = ctrl.dir ? rf_addr  : per_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= 1'b0;
      dat_q <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= done && at_end && ctrl.irq_en;
      case (state)
        ST_IDLE: if (take) begin
          state <= ST_RD;
          idx   <= 1'b0;
        end
        ST_RD: if (bus_ready) begin
          dat_q <= bus_rdata;
          state <= ST_WR;
        end
        ST_WR: if (bus_ready) begin
          if (ctrl.word && !idx) begin
            idx   <= 1'b1;
            state <= ST_RD;
          end else begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign bus_valid = state != ST_IDLE;
  assign bus_we    = state == ST_WR;
  assign bus_addr  = (state == ST_WR) ? dst_addr : src_addr;
  assign bus_wdata = dat_q;
endmodule

// File: rtl/dmach_chk.sv
module dmach_chk
  import dmach_pkg::*;
#(
  parameter int AW  = 12,
  parameter int IOW = 8,
  parameter logic [AW-IOW-1:0] PAGE = '1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_valid,
  input logic          bus_ready,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic          irq,
  input ctrl_t         ctl,
  input st_e           st,
  input logic          pend
);
  assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(ctl.irq_en));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_we));

  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.en && st == ST_IDLE |=> !bus_valid);

  assert_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && (bus_we != ctl.dir) |-> bus_addr[AW-1:IOW] == PAGE);

  assert_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.src == 3'd7 && !pend |=> !pend);
endmodule

bind dmach_chan dmach_chk #(.AW(AW), .IOW(IOW), .PAGE(PAGE)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
  .bus_we(bus_we), .bus_addr(bus_addr), .irq(irq), .ctl(ctrl),
  .st(state), .pend(pend)
);

// File: tb/sim_dmach_chan.sv
`timescale 1ns/1ps
module sim_dmach_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [11:0] cfg_data = '0;
  logic [6:0]  trig = '0;
  logic        bus_valid, bus_we, bus_ready = 1'b0, irq;
  logic [11:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;

  logic [7:0]  mem [0:4095];
  int wr_cnt = 0, irq_cnt = 0, vld_cnt = 0;
  int checks = 0, fails = 0, delay = 0, wcnt = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dmach_chan u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .trig(trig), .bus_valid(bus_valid),
    .bus_ready(bus_ready), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  assign bus_rdata = mem[bus_addr];

  always @(posedge clk) begin
    if (bus_valid && bus_ready && bus_we) begin
      mem[bus_addr] <= bus_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (irq) irq_cnt <= irq_cnt + 1;
    if (bus_valid) vld_cnt <= vld_cnt + 1;
  end

  always @(negedge clk) begin
    if (bus_ready) begin
      bus_ready = 1'b0;
      wcnt = 0;
    end else if (bus_valid) begin
      if (wcnt >= delay) bus_ready = 1'b1;
      else wcnt++;
    end
  end

  function automatic logic [11:0] ctl(input bit en, input bit lp, input bit dir,
                                       input bit ie, input bit wd, input logic [2:0] s);
    return {4'h0, s, wd, ie, dir, lp, en};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] s, input logic [11:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input int k);
    @(negedge clk); trig[k] = 1'b1;
    @(negedge clk); trig[k] = 1'b0;
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(bus_valid == 1'b0, "R10 reset valid", int'(bus_valid), 0);
    check(irq == 1'b0, "R7 reset irq", int'(irq), 0);
  endtask

  task automatic t_byte_stop();
    int w0, i0;
    logic [7:0] exp_v [3] = '{8'h11, 8'h22, 8'h33};
    mem[12'h100] = 8'h11; mem[12'h101] = 8'h22; mem[12'h102] = 8'h33;
    cfg(2'd0, 12'h000);
    cfg(2'd1, 12'h020);
    cfg(2'd2, 12'h100);
    cfg(2'd3, 12'h102);
    i0 = irq_cnt;
    cfg(2'd0, ctl(1, 0, 0, 1, 0, 3'd0));
    for (int i = 0; i < 3; i++) begin
      w0 = wr_cnt;
      pulse(0);
      settle();
      check(mem[12'hF20] == exp_v[i], "R2 R3 rf to periph byte", mem[12'hF20], exp_v[i]);
      check(wr_cnt == w0 + 1, "R4 one byte per request", wr_cnt - w0, 1);
    end
    check(irq_cnt == i0 + 1, "R7 single irq cycle at end", irq_cnt - i0, 1);
    w0 = wr_cnt;
    pulse(0);
    settle();
    check(wr_cnt == w0, "R5 stopped after end", wr_cnt - w0, 0);
    cfg(2'd0, ctl(1, 0, 0, 1, 0, 3'd0));
    pulse(0);
    settle();
    check(mem[12'hF20] == 8'h11, "R5 reload start", mem[12'hF20], 8'h11);
  endtask

  task automatic t_wrong_src();
    int w0;
    cfg(2'd0, 12'h000);
    cfg(2'd2, 12'h100);
    cfg(2'd3, 12'h10F);
    cfg(2'd0, ctl(1, 1, 0, 0, 0, 3'd2));
    w0 = wr_cnt;
    pulse(0); pulse(1); pulse(3);
    settle();
    check(wr_cnt == w0, "R1 other trigger ignored", wr_cnt - w0, 0);
    pulse(2);
    settle();
    check(wr_cnt == w0 + 1, "R1 selected trigger", wr_cnt - w0, 1);
  endtask

  task automatic t_word_loop();
    int w0, i0;
    cfg(2'd0, 12'h000);
    cfg(2'd1, 12'h041);
    cfg(2'd2, 12'h200);
    cfg(2'd3, 12'h202);
    cfg(2'd0, ctl(1, 1, 1, 0, 1, 3'd3));
    i0 = irq_cnt;
    mem[12'hF40] = 8'hA1; mem[12'hF41] = 8'hB2;
    w0 = wr_cnt;
    pulse(3); settle();
    check(mem[12'h200] == 8'hA1 && mem[12'h201] == 8'hB2, "R3 even periph word",
          {mem[12'h200], mem[12'h201]}, 16'hA1B2);
    check(wr_cnt == w0 + 2, "R4 two bytes per request", wr_cnt - w0, 2);
    mem[12'hF40] = 8'hC3; mem[12'hF41] = 8'hD4;
    pulse(3); settle();
    check(mem[12'h202] == 8'hC3 && mem[12'h203] == 8'hD4, "R4 pointer plus two",
          {mem[12'h202], mem[12'h203]}, 16'hC3D4);
    mem[12'hF40] = 8'hE5; mem[12'hF41] = 8'hF6;
    pulse(3); settle();
    check(mem[12'h200] == 8'hE5 && mem[12'h201] == 8'hF6, "R6 loop wraps",
          {mem[12'h200], mem[12'h201]}, 16'hE5F6);
    pulse(3); settle();
    check(mem[12'h202] == 8'hE5, "R6 still enabled", mem[12'h202], 8'hE5);
    check(irq_cnt == i0, "R7 no irq when disabled", irq_cnt - i0, 0);
  endtask

  task automatic t_reserved();
    int w0;
    cfg(2'd0, 12'h000);
    cfg(2'd0, ctl(1, 1, 0, 0, 0, 3'd7));
    w0 = wr_cnt;
    @(negedge clk); trig = 7'h7F;
    @(negedge clk); trig = 7'h00;
    settle();
    check(wr_cnt == w0, "R8 reserved code idle", wr_cnt - w0, 0);
  endtask

  task automatic t_pending();
    int w0;
    delay = 3;
    mem[12'h300] = 8'h5A; mem[12'h301] = 8'h6B;
    cfg(2'd0, 12'h000);
    cfg(2'd1, 12'h020);
    cfg(2'd2, 12'h300);
    cfg(2'd3, 12'h30F);
    cfg(2'd0, ctl(1, 1, 0, 0, 0, 3'd4));
    w0 = wr_cnt;
    pulse(4);
    @(negedge clk);
    pulse(4);
    repeat (60) @(negedge clk);
    check(wr_cnt == w0 + 2, "R9 pending request served", wr_cnt - w0, 2);
    check(mem[12'hF20] == 8'h6B, "R9 R10 data under back-pressure", mem[12'hF20], 8'h6B);
    w0 = wr_cnt;
    @(negedge clk); trig[4] = 1'b1;
    repeat (12) @(negedge clk);
    trig[4] = 1'b0;
    repeat (40) @(negedge clk);
    check(wr_cnt == w0 + 1, "R9 level counts once", wr_cnt - w0, 1);
    delay = 0;
  endtask

  task automatic t_disabled();
    int w0, v0;
    cfg(2'd0, 12'h000);
    w0 = wr_cnt; v0 = vld_cnt;
    cfg(2'd2, 12'h100);
    cfg(2'd0, ctl(0, 1, 0, 1, 0, 3'd0));
    pulse(0);
    settle();
    check(vld_cnt == v0, "R10 no bus activity disabled", vld_cnt - v0, 0);
    check(wr_cnt == w0, "R10 no write disabled", wr_cnt - w0, 0);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_byte_stop();
    t_wrong_src();
    t_word_loop();
    t_reserved();
    t_pending();
    t_disabled();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule